// File: doc/BRIEF.md
# Multi-cycle multiply/divide unit with HI/LO result pair

This block carries out 32-bit multiply and divide operations in the background of a pipeline. A one-cycle start strobe selects one of four operations: signed multiply, unsigned multiply, signed divide or unsigned divide. It also supplies the two operands. The unit then works for a fixed number of cycles. Meanwhile the pipeline keeps issuing other work. Results land in a dedicated register pair, HI and LO, rather than in a general register. No destination field is needed, because the operation takes far longer than an ordinary ALU step.

A multiply writes the upper half of the 64-bit product to HI and the lower half to LO. A divide writes the quotient to LO and the remainder to HI. Two direct write ports load HI or LO from a general register value. The `busy` output tells the pipeline to hold any read of HI or LO until the running operation has written its result. None of the operations reports overflow or any other exception.

Top module: `mdu_hilo`

## Requirements
- R1: After a synchronous reset, HI and LO read zero and `busy` is low.
- R2: Operation code 2'b00 (signed multiply) leaves the 64-bit two's-complement product of the operands in {HI, LO}, with HI the upper 32 bits.
- R3: Operation code 2'b01 (unsigned multiply) leaves the 64-bit unsigned product in {HI, LO}.
- R4: Operation code 2'b10 (signed divide) leaves in LO the quotient truncated toward zero and in HI the remainder, which carries the sign of the dividend. The most negative dividend divided by -1 gives LO = 0x80000000 and HI = 0, and nothing is flagged.
- R5: Operation code 2'b11 (unsigned divide) leaves the unsigned quotient in LO and the unsigned remainder in HI.
- R6: Timing and visibility of a result:
  - `busy` is high from the clock edge that samples `start` until the edge that writes the result.
  - That write happens on the 33rd edge after the sampling edge.
  - Up to that edge, HI and LO keep their previous values.
- R7: A `start` sampled while `busy` is high abandons the running operation and begins the new one, with the full latency counted from the new start. Only the new result is written.
- R8: With no operation running, `hi_wr` loads `wr_data` into HI on the next edge, and `lo_wr` does the same for LO. The other register is unchanged.
- R9: A direct write (`hi_wr` or `lo_wr`) without `start` while `busy` is high cancels the operation. `busy` falls on that edge, and the cancelled result never reaches HI or LO.
- R10: Unsigned divide by zero finishes normally, with LO = 0xFFFFFFFF and HI = the dividend.
- R11: While `busy` is low, HI and LO change only through their direct write ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that begins an operation |
| op | input | 2 | Operation: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| hi_wr | input | 1 | Write `wr_data` into HI |
| lo_wr | input | 1 | Write `wr_data` into LO |
| wr_data | input | 32 | Data for direct HI/LO writes |
| hi_out | output | 32 | Current HI value |
| lo_out | output | 32 | Current LO value |
| busy | output | 1 | Operation in progress; reads of HI/LO must wait |

## Verification
The hardest situations to reach are those where the operation in flight is interrupted part-way through:
- a new start arriving several cycles into a multiply, which must throw away the partial product;
- a direct HI write during a divide, which must cancel it so that no late result overwrites LO.

The stimulus launches an operation, waits a chosen number of cycles, then applies the interrupting strobe. A scoreboard expects exactly one busy fall for each interrupted sequence. Later cycles are checked to confirm that HI and LO stay put. The same path covers the cases with extreme operands: most-negative values, all-ones, and a zero divisor.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    // Operation codes; bit 1 picks divide, bit 0 picks unsigned
    typedef enum logic [1:0] {
        MD_MUL_S = 2'b00,
        MD_MUL_U = 2'b01,
        MD_DIV_S = 2'b10,
        MD_DIV_U = 2'b11
    } md_op_e;

    // Sign corrections applied to the magnitude result
    typedef struct packed {
        logic flip_hi;
        logic flip_lo;
    } sign_fix_t;

    function automatic logic op_is_div(input md_op_e o);
        logic [1:0] v;
        v = o;
        return v[1];
    endfunction

    function automatic logic op_is_signed(input md_op_e o);
        logic [1:0] v;
        v = o;
        return ~v[0];
    endfunction

endpackage

// File: rtl/mdu_mul_seq.sv
module mdu_mul_seq #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         drop,
    input  logic         is_signed,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    import mdu_pkg::*;

    localparam int CW = $clog2(W + 1);
    localparam int PW = 2 * W;

    logic            active;
    logic [CW-1:0]   cnt;
    logic [PW-1:0]   prod;
    logic [W-1:0]    mcand;
    sign_fix_t       fix;

    logic [W-1:0]    mag_a, mag_b;
    logic [W:0]      upper_sum;
    logic [PW-1:0]   prod_step;
    logic [PW-1:0]   signed_prod;

    // Operand magnitudes for the unsigned shift-add core
    always_comb begin
        mag_a = (is_signed && a[W-1]) ? (~a + 1'b1) : a;
        mag_b = (is_signed && b[W-1]) ? (~b + 1'b1) : b;
    end

    // One shift-add step: conditionally add, then shift right
    always_comb begin
        upper_sum = {1'b0, prod[PW-1:W]} + (prod[0] ? {1'b0, mcand} : '0);
        prod_step = {upper_sum, prod[W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            prod   <= '0;
            mcand  <= '0;
            fix    <= '0;
        end else if (load) begin
            active       <= 1'b1;
            cnt          <= CW'(W);
            prod         <= {{W{1'b0}}, mag_a};
            mcand        <= mag_b;
            fix.flip_hi  <= is_signed & (a[W-1] ^ b[W-1]);
            fix.flip_lo  <= is_signed & (a[W-1] ^ b[W-1]);
        end else if (drop) begin
            active <= 1'b0;
        end else if (active && cnt != '0) begin
            prod <= prod_step;
            cnt  <= cnt - CW'(1);
        end else if (active) begin
            active <= 1'b0;
        end
    end

    assign signed_prod = fix.flip_lo ? (~prod + 1'b1) : prod;
    assign busy = active;
    assign done = active && (cnt == '0);
    assign hi   = signed_prod[PW-1:W];
    assign lo   = signed_prod[W-1:0];

    // R6: a running multiply advances exactly one step per cycle
    a_r6_mul_step: assert property (@(posedge clk) disable iff (rst)
        (active && cnt != '0 && !load && !drop) |=> (active && cnt == $past(cnt) - CW'(1)));

    // R6: the finishing cycle retires the engine unless reloaded
    a_r6_mul_retire: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> !active);

endmodule

// File: rtl/mdu_div_seq.sv
module mdu_div_seq #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         drop,
    input  logic         is_signed,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    import mdu_pkg::*;

    localparam int CW = $clog2(W + 1);

    logic            active;
    logic [CW-1:0]   cnt;
    logic [W-1:0]    rem;
    logic [W-1:0]    quo;
    logic [W-1:0]    dvsr;
    sign_fix_t       fix;

    logic [W-1:0]    mag_a, mag_b;
    logic [W:0]      shifted;
    logic [W:0]      diff;

    always_comb begin
        mag_a = (is_signed && a[W-1]) ? (~a + 1'b1) : a;
        mag_b = (is_signed && b[W-1]) ? (~b + 1'b1) : b;
    end

    // Restoring step: bring in next dividend bit, trial-subtract divisor
    always_comb begin
        shifted = {rem, quo[W-1]};
        diff    = shifted - {1'b0, dvsr};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            rem    <= '0;
            quo    <= '0;
            dvsr   <= '0;
            fix    <= '0;
        end else if (load) begin
            active      <= 1'b1;
            cnt         <= CW'(W);
            rem         <= '0;
            quo         <= mag_a;
            dvsr        <= mag_b;
            fix.flip_lo <= is_signed & (a[W-1] ^ b[W-1]);
            fix.flip_hi <= is_signed & a[W-1];
        end else if (drop) begin
            active <= 1'b0;
        end else if (active && cnt != '0) begin
            if (!diff[W]) begin
                rem <= diff[W-1:0];
                quo <= {quo[W-2:0], 1'b1};
            end else begin
                rem <= shifted[W-1:0];
                quo <= {quo[W-2:0], 1'b0};
            end
            cnt <= cnt - CW'(1);
        end else if (active) begin
            active <= 1'b0;
        end
    end

    assign busy = active;
    assign done = active && (cnt == '0);
    assign lo   = fix.flip_lo ? (~quo + 1'b1) : quo;
    assign hi   = fix.flip_hi ? (~rem + 1'b1) : rem;

    // R4/R5: partial remainder stays below a nonzero divisor
    a_r5_rem_bound: assert property (@(posedge clk) disable iff (rst)
        (active && dvsr != '0) |-> (rem < dvsr));

    // R6: the finishing cycle retires the engine unless reloaded
    a_r6_div_retire: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> !active);

endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic         hi_wr,
    input  logic         lo_wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] hi_out,
    output logic [W-1:0] lo_out,
    output logic         busy
);
    import mdu_pkg::*;

    md_op_e       op_e;
    logic         mt_any;
    logic         drop_all;
    logic         wb_ok;
    logic         mul_load, div_load;
    logic         op_signed;
    logic         mul_busy, mul_done;
    logic         div_busy, div_done;
    logic [W-1:0] mul_hi, mul_lo, div_hi, div_lo;
    logic [W-1:0] hi_q, lo_q;

    assign op_e      = md_op_e'(op);
    assign op_signed = op_is_signed(op_e);
    assign mt_any    = hi_wr | lo_wr;
    assign mul_load  = start & ~op_is_div(op_e);
    assign div_load  = start &  op_is_div(op_e);
    // Any start or direct write ends whatever is running
    assign drop_all  = start | mt_any;
    // A finishing result is discarded if overtaken in the same cycle
    assign wb_ok     = ~start & ~mt_any;

    mdu_mul_seq #(.W(W)) u_mul (
        .clk       (clk),
        .rst       (rst),
        .load      (mul_load),
        .drop      (drop_all),
        .is_signed (op_signed),
        .a         (src_a),
        .b         (src_b),
        .busy      (mul_busy),
        .done      (mul_done),
        .hi        (mul_hi),
        .lo        (mul_lo)
    );

    mdu_div_seq #(.W(W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .load      (div_load),
        .drop      (drop_all),
        .is_signed (op_signed),
        .a         (src_a),
        .b         (src_b),
        .busy      (div_busy),
        .done      (div_done),
        .hi        (div_hi),
        .lo        (div_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (hi_wr)                  hi_q <= wr_data;
            else if (wb_ok && mul_done) hi_q <= mul_hi;
            else if (wb_ok && div_done) hi_q <= div_hi;

            if (lo_wr)                  lo_q <= wr_data;
            else if (wb_ok && mul_done) lo_q <= mul_lo;
            else if (wb_ok && div_done) lo_q <= div_lo;
        end
    end

    assign hi_out = hi_q;
    assign lo_out = lo_q;
    assign busy   = mul_busy | div_busy;

    // R6: a sampled start raises busy on the next cycle
    a_r6_busy_on_start: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R9: a direct write without start cancels any running operation
    a_r9_cancel: assert property (@(posedge clk) disable iff (rst)
        (mt_any && !start) |=> !busy);

    // R7: at most one engine is ever running
    a_r7_one_engine: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mul_busy, div_busy}));

    // R11: idle HI/LO move only through their write ports
    a_r11_hi_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !hi_wr) |=> $stable(hi_q));
    a_r11_lo_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !lo_wr) |=> $stable(lo_q));

    // R6: while an operation is still stepping, HI keeps its old value
    a_r6_hold_running: assert property (@(posedge clk) disable iff (rst)
        (busy && !hi_wr && !mul_done && !div_done) |=> $stable(hi_q));

endmodule

// File: tb/mdu_hilo_test.sv
`timescale 1ns/1ps
module mdu_hilo_test;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [1:0]    op;
    logic [W-1:0]  src_a, src_b;
    logic          hi_wr, lo_wr;
    logic [W-1:0]  wr_data;
    logic [W-1:0]  hi_out, lo_out;
    logic          busy;

    typedef struct {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        string        tag;
    } exp_t;

    exp_t  sb_q[$];
    int    checks = 0;
    int    errors = 0;
    logic  [W-1:0] m_hi = '0, m_lo = '0;

    always #2 clk = ~clk;

    mdu_hilo #(.W(W)) uut (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .hi_wr(hi_wr), .lo_wr(lo_wr),
        .wr_data(wr_data), .hi_out(hi_out), .lo_out(lo_out), .busy(busy)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model from the requirements
    task automatic calc(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                        output logic [W-1:0] eh, output logic [W-1:0] el);
        longint sa, sbv, q, r;
        logic [63:0] p;
        sa  = longint'($signed(a));
        sbv = longint'($signed(b));
        case (o)
            2'b00: begin p = 64'(sa * sbv); eh = p[63:32]; el = p[31:0]; end
            2'b01: begin p = {32'b0, a} * {32'b0, b}; eh = p[63:32]; el = p[31:0]; end
            2'b10: begin q = sa / sbv; r = sa % sbv; eh = r[31:0]; el = q[31:0]; end
            default: begin
                if (b == '0) begin eh = a; el = '1; end
                else begin eh = a % b; el = a / b; end
            end
        endcase
    endtask

    // Scoreboard monitor: every busy fall retires one expected item
    initial begin : monitor
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (prev && !busy) begin
                if (sb_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R7: unexpected completion, actual hi %h lo %h expected none", hi_out, lo_out);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk({e.tag, " HI"}, hi_out, e.hi);
                    chk({e.tag, " LO"}, lo_out, e.lo);
                end
            end
            prev = busy;
        end
    end

    task automatic pulse_start(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
        start = 1'b1; op = o; src_a = a; src_b = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Full operation with latency and hold checks (R6)
    task automatic run_op(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                          input string tag);
        logic [W-1:0] eh, el;
        exp_t e;
        calc(o, a, b, eh, el);
        e.hi = eh; e.lo = el; e.tag = tag;
        sb_q.push_back(e);
        pulse_start(o, a, b);
        chk("R6 busy after start", {31'b0, busy}, 32'd1);
        repeat (W) @(negedge clk);
        chk("R6 busy on last step", {31'b0, busy}, 32'd1);
        chk("R6 HI held while busy", hi_out, m_hi);
        chk("R6 LO held while busy", lo_out, m_lo);
        @(negedge clk);
        chk("R6 busy falls", {31'b0, busy}, 32'd0);
        m_hi = eh; m_lo = el;
    endtask

    initial begin : driver
        logic [W-1:0] eh, el;
        exp_t e;
        rst = 1'b1; start = 1'b0; op = '0; src_a = '0; src_b = '0;
        hi_wr = 1'b0; lo_wr = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset HI", hi_out, '0);
        chk("R1 reset LO", lo_out, '0);
        chk("R1 reset busy", {31'b0, busy}, 32'd0);

        run_op(2'b00, -32'sd3, 32'd7, "R2 mul -3*7");
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000, "R2 mul min*min");
        run_op(2'b00, 32'd123456789, -32'sd987654321, "R2 mul mixed");
        run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 mulu ones");
        run_op(2'b01, 32'h1234_5678, 32'h9ABC_DEF0, "R3 mulu pattern");
        run_op(2'b10, -32'sd7, 32'd2, "R4 div -7/2");
        run_op(2'b10, 32'd7, -32'sd2, "R4 div 7/-2");
        run_op(2'b10, -32'sd7, -32'sd2, "R4 div -7/-2");
        run_op(2'b10, 32'd100, 32'd7, "R4 div 100/7");
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R4 div min/-1");
        run_op(2'b11, 32'hFFFF_FFFF, 32'd16, "R5 divu ones/16");
        run_op(2'b11, 32'd5, 32'd9, "R5 divu 5/9");
        run_op(2'b11, 32'hDEAD_BEEF, 32'd0, "R10 divu by zero");

        // R8: direct writes while idle
        hi_wr = 1'b1; wr_data = 32'hA5A5_0001;
        @(negedge clk);
        hi_wr = 1'b0;
        chk("R8 HI written", hi_out, 32'hA5A5_0001);
        chk("R8 LO untouched", lo_out, m_lo);
        m_hi = 32'hA5A5_0001;
        lo_wr = 1'b1; wr_data = 32'h0F0F_0002;
        @(negedge clk);
        lo_wr = 1'b0;
        chk("R8 LO written", lo_out, 32'h0F0F_0002);
        chk("R8 HI untouched", hi_out, m_hi);
        m_lo = 32'h0F0F_0002;

        // R11: idle cycles with operand changes leave HI/LO alone
        src_a = 32'h1111_1111; src_b = 32'h2222_2222; op = 2'b01;
        repeat (5) @(negedge clk);
        chk("R11 HI idle hold", hi_out, m_hi);
        chk("R11 LO idle hold", lo_out, m_lo);

        // R7: restart a multiply with a divide part-way through
        pulse_start(2'b00, 32'd1000, 32'd1000);
        repeat (10) @(negedge clk);
        calc(2'b10, -32'sd50, 32'd6, eh, el);
        e.hi = eh; e.lo = el; e.tag = "R7 restart result";
        sb_q.push_back(e);
        pulse_start(2'b10, -32'sd50, 32'd6);
        repeat (W - 1) @(negedge clk);
        chk("R7 busy from new start", {31'b0, busy}, 32'd1);
        chk("R7 HI not from old op", hi_out, m_hi);
        repeat (3) @(negedge clk);
        chk("R7 idle after restart", {31'b0, busy}, 32'd0);
        m_hi = eh; m_lo = el;

        // R9: direct HI write cancels a running divide
        pulse_start(2'b11, 32'd999, 32'd3);
        repeat (5) @(negedge clk);
        e.hi = 32'h5555_AAAA; e.lo = m_lo; e.tag = "R9 cancel";
        sb_q.push_back(e);
        hi_wr = 1'b1; wr_data = 32'h5555_AAAA;
        @(negedge clk);
        hi_wr = 1'b0;
        chk("R9 busy dropped", {31'b0, busy}, 32'd0);
        m_hi = 32'h5555_AAAA;
        repeat (W + 4) @(negedge clk);
        chk("R9 no late HI write", hi_out, m_hi);
        chk("R9 no late LO write", lo_out, m_lo);
        chk("R9 queue drained", 32'(sb_q.size()), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule